// File: doc/BRIEF.md
# Watchdog Timer with Reset or Interrupt Escalation

This block is an 8-bit up-counting watchdog. Once software enables it and selects watchdog mode, each `tick` moves the counter up by one. Software must write the counter back to zero before it passes 0xFF. If the counter wraps from 0xFF to 0x00, a control bit decides the result. One setting raises a single-cycle non-maskable interrupt request. The other setting starts a chip reset. That reset is a long internal pulse plus a shorter active-low external pulse, and both begin in the same cycle.

The block tracks where the most recent reset came from. A synchronous pin reset sets this source bit and a watchdog reset clears it. When both arrive in the same cycle, the pin reset wins. The internal reset that the watchdog produces also resets the block itself: the counter returns to zero, the control bits return to their defaults, and the overflow flag clears. The pulse lengths are parameters. Register access uses a one-bit address. Writes take one cycle and reads are combinational.

Top module: `wdog_core`

## Requirements
- R1: While the enable bit (control bit 5) and the watchdog-mode bit (control bit 6) are both 1, each cycle with `tick` high increments the counter, which reads at address 0; with `tick` low it holds.
- R2: A write to address 0 loads the counter, and it wins over a `tick` in the same cycle.
- R3: With reset-select (control bit 4) at 1, a tick at count 0xFF drives `int_rst` high for exactly INT_LEN (default 518) cycles, starting the cycle after that edge.
- R4: In that same overflow, `ext_rst_n` goes low in the same cycle as `int_rst` for EXT_LEN (default 132) cycles, then returns high while `int_rst` is still high.
- R5: With reset-select at 0, an overflow gives a one-cycle `nmi_req` pulse; `int_rst` stays low, `ext_rst_n` stays high, and the counter wraps to 0x00 and keeps counting.
- R6: The overflow flag (control bit 7) is set by any overflow. After a reset-type overflow it reads 1 in the first cycle of `int_rst` and 0 after that. After an interrupt-type overflow it stays at 1 until software writes control with bit 7 at 0; writing bit 7 as 1 has no effect.
- R7: From the second cycle of `int_rst` onward, the counter reads 0x00 and control bits 6..4 read 0 (disabled, interval mode, interrupt selected). Writes are ignored while `int_rst` is high.
- R8: The reset-source bit (control bit 0, read-only) reads 1 after a pin reset and 0 after a watchdog reset. An interrupt-type overflow leaves it unchanged.
- R9: If `pin_rst_n` is low in the same cycle as a reset-type overflow, the pin reset wins: the source bit reads 1, `int_rst` stays low and `ext_rst_n` stays high.
- R10: With the enable bit at 0, or with the mode bit at 0 (interval mode), `tick` does not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| pin_rst_n | input | 1 | External pin reset, active low, sampled synchronously |
| tick | input | 1 | Count-enable pulse from the prescaler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Write address: 0 counter, 1 control |
| wr_data | input | 8 | Write data |
| rd_addr | input | 1 | Read address: 0 counter, 1 control |
| rd_data | output | 8 | Combinational read data |
| int_rst | output | 1 | Internal reset pulse, active high |
| ext_rst_n | output | 1 | External reset output, active low |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |

## Verification
The assertions assume that `pin_rst_n` is held low for the first clock edges, so every register has a known value before the first checked cycle. They also assume that the pin reset is never asserted partway through a watchdog pulse unless that pulse is excluded from the length checks. The bench releases the pin reset before it configures the block, and it asserts the pin reset again only in the collision case, when no pulse is running. The checker tracks pulses cut short by the pin reset so that they do not count against the length properties.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    localparam int ADDR_CNT  = 0;
    localparam int ADDR_CTRL = 1;

    localparam int BIT_OVF  = 7;
    localparam int BIT_MODE = 6;
    localparam int BIT_EN   = 5;
    localparam int BIT_RSEL = 4;
    localparam int BIT_SRC  = 0;

    typedef struct packed {
        logic mode;     // 1 = watchdog, 0 = interval
        logic en;
        logic rst_sel;  // 1 = reset on overflow, 0 = interrupt
    } ctrl_t;

    localparam ctrl_t CTRL_DEFAULT = '{mode: 1'b0, en: 1'b0, rst_sel: 1'b0};

    typedef struct packed {
        ctrl_t ctrl;
        logic  ovf;
        logic  src;
        logic  nmi;
    } core_st_t;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         clr,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    output logic [W-1:0] value,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        wrap  = step && !load && !clr && (cnt_q == {W{1'b1}});
        cnt_d = cnt_q;
        if (clr)
            cnt_d = '0;
        else if (load)
            cnt_d = load_val;
        else if (step)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        cnt_q <= cnt_d;
    end

    assign value = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
    parameter int LEN = 518
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (clr)
            left_d = '0;
        else if (start)
            left_d = CW'(LEN);
        else if (left_q != '0)
            left_d = left_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        left_q <= left_d;
    end

    assign active = (left_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int INT_LEN = 518,
    parameter int EXT_LEN = 132
) (
    input  logic       clk,
    input  logic       pin_rst_n,
    input  logic       tick,
    input  logic       wr_en,
    input  logic       wr_addr,
    input  logic [7:0] wr_data,
    input  logic       rd_addr,
    output logic [7:0] rd_data,
    output logic       int_rst,
    output logic       ext_rst_n,
    output logic       nmi_req
);
    localparam int DW = 8;

    core_st_t st_d, st_q;

    logic             pin_rst;
    logic             hold;
    logic             step;
    logic             wrap;
    logic             wr_cnt;
    logic             wr_ctl;
    logic             wd_start;
    logic             ext_active;
    logic [CNT_W-1:0] cnt_val;

    assign pin_rst  = !pin_rst_n;
    assign hold     = pin_rst || int_rst;
    assign step     = tick && st_q.ctrl.en && st_q.ctrl.mode && !hold;
    assign wr_cnt   = wr_en && (wr_addr == 1'(ADDR_CNT)) && !hold;
    assign wr_ctl   = wr_en && (wr_addr == 1'(ADDR_CTRL)) && !hold;
    assign wd_start = wrap && st_q.ctrl.rst_sel;

    wdog_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .clr      (hold),
        .load     (wr_cnt),
        .load_val (wr_data[CNT_W-1:0]),
        .step     (step),
        .value    (cnt_val),
        .wrap     (wrap)
    );

    wdog_pulse #(.LEN(INT_LEN)) u_int_pulse (
        .clk    (clk),
        .clr    (pin_rst),
        .start  (wd_start),
        .active (int_rst)
    );

    wdog_pulse #(.LEN(EXT_LEN)) u_ext_pulse (
        .clk    (clk),
        .clr    (pin_rst),
        .start  (wd_start),
        .active (ext_active)
    );

    assign ext_rst_n = !ext_active;
    assign nmi_req   = st_q.nmi;

    always_comb begin
        st_d     = st_q;
        st_d.nmi = 1'b0;
        if (pin_rst) begin
            st_d.ctrl = CTRL_DEFAULT;
            st_d.ovf  = 1'b0;
            st_d.src  = 1'b1;
        end else if (int_rst) begin
            st_d.ctrl = CTRL_DEFAULT;
            st_d.ovf  = 1'b0;
        end else begin
            if (wr_ctl) begin
                st_d.ctrl.mode    = wr_data[BIT_MODE];
                st_d.ctrl.en      = wr_data[BIT_EN];
                st_d.ctrl.rst_sel = wr_data[BIT_RSEL];
                st_d.ovf          = st_q.ovf && wr_data[BIT_OVF];
            end
            if (wrap) begin
                st_d.ovf = 1'b1;
                if (st_q.ctrl.rst_sel)
                    st_d.src = 1'b0;
                else
                    st_d.nmi = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == 1'(ADDR_CNT)) begin
            rd_data = DW'(cnt_val);
        end else begin
            rd_data[BIT_OVF]  = st_q.ovf;
            rd_data[BIT_MODE] = st_q.ctrl.mode;
            rd_data[BIT_EN]   = st_q.ctrl.en;
            rd_data[BIT_RSEL] = st_q.ctrl.rst_sel;
            rd_data[BIT_SRC]  = st_q.src;
        end
    end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
    parameter int INT_LEN = 518,
    parameter int EXT_LEN = 132
) (
    input logic clk,
    input logic pin_rst_n,
    input logic int_rst,
    input logic ext_rst_n,
    input logic nmi_req,
    input logic ovf,
    input logic src
);
    logic [31:0] hi_run_q, lo_run_q;
    logic        cut_q;

    always_ff @(posedge clk) begin
        if (!pin_rst_n) begin
            hi_run_q <= '0;
            lo_run_q <= '0;
            cut_q    <= 1'b1;
        end else begin
            hi_run_q <= int_rst ? hi_run_q + 1 : '0;
            lo_run_q <= !ext_rst_n ? lo_run_q + 1 : '0;
            if (!int_rst)
                cut_q <= 1'b0;
        end
    end

    // R3: internal pulse lasts INT_LEN cycles
    a_r3_int_len: assert property (@(posedge clk) disable iff (!pin_rst_n)
        ($fell(int_rst) && !cut_q) |-> (hi_run_q == 32'(INT_LEN)));

    // R4: external pulse lasts EXT_LEN cycles and sits inside the internal one
    a_r4_ext_len: assert property (@(posedge clk) disable iff (!pin_rst_n)
        ($rose(ext_rst_n) && !cut_q) |-> (lo_run_q == 32'(EXT_LEN)));

    a_r4_ext_inside: assert property (@(posedge clk) disable iff (!pin_rst_n)
        !ext_rst_n |-> int_rst);

    a_r4_start_together: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $rose(int_rst) |-> !ext_rst_n);

    // R5: interrupt request is one cycle and never comes with a reset
    a_r5_nmi_single: assert property (@(posedge clk) disable iff (!pin_rst_n)
        nmi_req |=> !nmi_req);

    a_r5_nmi_no_reset: assert property (@(posedge clk) disable iff (!pin_rst_n)
        nmi_req |-> (ext_rst_n && !int_rst));

    // R6: overflow flag is cleared by the internal reset
    a_r6_ovf_cleared: assert property (@(posedge clk) disable iff (!pin_rst_n)
        (int_rst && $past(int_rst)) |-> !ovf);

    // R8: watchdog reset marks the source bit as 0
    a_r8_src_watchdog: assert property (@(posedge clk) disable iff (!pin_rst_n)
        $rose(int_rst) |-> !src);
endmodule

bind wdog_core wdog_chk #(.INT_LEN(INT_LEN), .EXT_LEN(EXT_LEN)) u_chk (
    .clk       (clk),
    .pin_rst_n (pin_rst_n),
    .int_rst   (int_rst),
    .ext_rst_n (ext_rst_n),
    .nmi_req   (nmi_req),
    .ovf       (st_q.ovf),
    .src       (st_q.src)
);

// File: tb/tb_wdog_core.sv
module tb_wdog_core;
    localparam int INT_LEN = 518;
    localparam int EXT_LEN = 132;

    logic       clk = 1'b0;
    logic       pin_rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_addr = 1'b0;
    logic [7:0] rd_data;
    logic       int_rst, ext_rst_n, nmi_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wdog_core #(.CNT_W(8), .INT_LEN(INT_LEN), .EXT_LEN(EXT_LEN)) dut (
        .clk(clk), .pin_rst_n(pin_rst_n), .tick(tick), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .int_rst(int_rst), .ext_rst_n(ext_rst_n),
        .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        pin_rst_n = 1'b0;
        repeat (4) @(negedge clk);
        pin_rst_n = 1'b1;
        @(negedge clk);
        rd(1'b0, v); chk("R7 counter after pin reset", v, 8'h00);
        rd(1'b1, v); chk("R8 ctrl after pin reset", v, 8'h01);
        chk("R3 int_rst idle", int_rst, 0);
        chk("R4 ext_rst_n idle", ext_rst_n, 1);
        chk("R5 nmi idle", nmi_req, 0);
    endtask

    task automatic t_count();
        logic [7:0] v;
        wr(1'b1, 8'h20);
        tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
        rd(1'b0, v); chk("R10 interval mode holds", v, 8'h00);
        wr(1'b1, 8'h40);
        tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
        rd(1'b0, v); chk("R10 disabled holds", v, 8'h00);
        wr(1'b1, 8'h60);
        tick = 1'b1; repeat (5) @(negedge clk); tick = 1'b0;
        rd(1'b0, v); chk("R1 five ticks", v, 8'h05);
        repeat (3) @(negedge clk);
        rd(1'b0, v); chk("R1 hold without tick", v, 8'h05);
    endtask

    task automatic t_service();
        logic [7:0] v;
        @(negedge clk);
        tick = 1'b1; wr_en = 1'b1; wr_addr = 1'b0; wr_data = 8'h00;
        @(negedge clk);
        tick = 1'b0; wr_en = 1'b0;
        rd(1'b0, v); chk("R2 write wins over tick", v, 8'h00);
        wr(1'b0, 8'hF0);
        rd(1'b0, v); chk("R2 load value", v, 8'hF0);
    endtask

    task automatic t_nmi();
        logic [7:0] v;
        wr(1'b1, 8'h60);
        wr(1'b0, 8'hFD);
        tick = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 no nmi before wrap", nmi_req, 0);
        @(negedge clk);
        chk("R5 nmi pulse", nmi_req, 1);
        chk("R5 ext stays high", ext_rst_n, 1);
        chk("R5 no int reset", int_rst, 0);
        rd(1'b0, v); chk("R5 wrapped to zero", v, 8'h00);
        rd(1'b1, v); chk("R6 R8 ovf set src kept", v, 8'hE1);
        @(negedge clk);
        tick = 1'b0;
        chk("R5 nmi one cycle", nmi_req, 0);
        rd(1'b0, v); chk("R5 keeps counting", v, 8'h01);
        wr(1'b1, 8'hE0);
        rd(1'b1, v); chk("R6 writing 1 keeps ovf", v, 8'hE1);
        wr(1'b1, 8'h60);
        rd(1'b1, v); chk("R6 writing 0 clears ovf", v, 8'h61);
    endtask

    task automatic t_wdreset();
        logic [7:0] v;
        int hi, lo, i;
        bit ext_rose_in_int;
        wr(1'b1, 8'h70);
        wr(1'b0, 8'hFF);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk("R3 int_rst starts", int_rst, 1);
        chk("R4 ext starts together", ext_rst_n, 0);
        rd(1'b1, v); chk("R6 R8 first reset cycle ctrl", v, 8'hF0);
        hi = 0; lo = 0; i = 0; ext_rose_in_int = 1'b0;
        while (int_rst && i < 2000) begin
            hi++;
            if (!ext_rst_n) lo++;
            else if (lo == EXT_LEN && hi == EXT_LEN + 1) ext_rose_in_int = 1'b1;
            if (i == 4) begin wr_en = 1'b1; wr_addr = 1'b1; wr_data = 8'h70; end
            if (i == 5) begin wr_addr = 1'b0; wr_data = 8'h55; end
            if (i == 6) wr_en = 1'b0;
            if (i == 8) begin
                rd(1'b0, v); chk("R7 counter zero and write ignored", v, 8'h00);
                rd(1'b1, v); chk("R7 R6 ctrl defaults in reset", v, 8'h00);
            end
            @(negedge clk);
            i++;
        end
        chk("R3 int_rst length", hi, INT_LEN);
        chk("R4 ext_rst_n length", lo, EXT_LEN);
        chk("R4 ext high while int high", ext_rose_in_int, 1);
        rd(1'b1, v); chk("R8 src after watchdog reset", v, 8'h00);
        rd(1'b0, v); chk("R7 counter after reset", v, 8'h00);
    endtask

    task automatic t_collide();
        logic [7:0] v;
        wr(1'b1, 8'h70);
        wr(1'b0, 8'hFF);
        @(negedge clk);
        tick = 1'b1; pin_rst_n = 1'b0;
        @(negedge clk);
        tick = 1'b0; pin_rst_n = 1'b1;
        chk("R9 no int reset", int_rst, 0);
        chk("R9 ext stays high", ext_rst_n, 1);
        rd(1'b1, v); chk("R9 src set by pin", v, 8'h01);
        repeat (3) @(negedge clk);
        chk("R9 int stays low", int_rst, 0);
        rd(1'b0, v); chk("R9 counter cleared", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_count();
        t_service();
        t_nmi();
        t_wdreset();
        t_collide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(8 * 50000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule